// File: doc/BRIEF.md
# Infrared Pulse Modulator and Demodulator

This block sits between the serial bit stream of a UART and an infrared transceiver. When pulse modulation is switched on, each 0 bit leaves the block as a single short high pulse on the infrared transmit line, and each 1 bit leaves no pulse. The idle line stays low. The pulse either takes 3 of the 16 ticks of the bit, so its width follows the baud rate, or, in low-power mode, it lasts a fixed number of ticks of an independent time base. When modulation is off, the UART line passes straight through in both directions.

On the receive side, the infrared line first goes through a synchronizer. A pulse that stays high for at least a minimum number of clock cycles drives the rebuilt line low for one full bit time. Shorter glitches are dropped. The line is half-duplex. While the demodulator is handling a received pulse, the transmit output is forced low so that the block's own echo is not sent back out. The UART is expected to send frames of 8 data bits, least significant bit first, framed by one start bit and one stop bit. The UART changes its line right after an active 16x tick.

The transmit side runs a three-state machine. TX_IDLE goes to TX_PULSE on a tick that sees a 0. TX_PULSE goes to TX_GAP when the pulse width has elapsed, or goes to the bit-end branch. At the 16th tick of the bit (bit end), TX_PULSE or TX_GAP goes to TX_PULSE if the line is still 0, and to TX_IDLE if it is 1. The receive side runs a second three-state machine. RX_IDLE goes to RX_QUAL when the synchronized line is high. RX_QUAL goes back to RX_IDLE if the line drops before the minimum width is reached, and goes to RX_HOLD once the width is reached. RX_HOLD goes to RX_IDLE after 16 ticks.

Top module: `sir_codec`

## Requirements
- R1: With `mod_en`=0, `ir_tx` equals `tx_nrz` in the same cycle, and `rx_nrz` equals `ir_rx` delayed by the two-stage synchronizer.
- R2: With `mod_en`=1, a pulse on `ir_tx` starts only at a `tick16` that samples `tx_nrz`=0. A 1 bit produces no pulse, and `ir_tx` idles low.
- R3: In normal mode (`low_pwr`=0), each 0 bit gives exactly one pulse, starting at the bit's first tick and lasting 3 `tick16` periods. Back-to-back 0 bits each get their own pulse, and the width scales with the tick period.
- R4: In low-power mode (`low_pwr`=1), the pulse ends on the 2nd `tick_fix` after it starts, whatever the tick16 rate is.
- R5: With `mod_en`=1, a received pulse that is accepted drives `rx_nrz` low for 16 `tick16` periods. Each of two pulses one bit apart gives its own low period.
- R6: A synchronized `ir_rx` high that lasts fewer than 3 consecutive clock cycles leaves `rx_nrz` high. A high of exactly 3 cycles is accepted.
- R7: With `mod_en`=1, `ir_tx` is held low while the demodulator is in RX_QUAL or RX_HOLD.
- R8: During reset with `mod_en`=1, `ir_tx` is 0 and `rx_nrz` is 1.
- R9: A frame made of a start bit (0), 8 data bits sent LSB first, and a stop bit (1) gives one pulse for the start bit and one for each 0 data bit. The stop bit gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle strobe, 16 per bit time |
| tick_fix | input | 1 | One-cycle strobe of the fixed time base used for low-power width |
| mod_en | input | 1 | 1: pulse modulation, 0: NRZ pass-through |
| low_pwr | input | 1 | 1: fixed-width pulse, 0: 3/16-bit pulse |
| tx_nrz | input | 1 | Serial bit stream from the UART |
| ir_rx | input | 1 | Pulse line from the transceiver (asynchronous) |
| ir_tx | output | 1 | Pulse line to the transceiver |
| rx_nrz | output | 1 | Rebuilt serial bit stream to the UART |

## Verification
The assertions check the following on every cycle: transmit pulses start only on a tick that samples a 0, the output stays blanked while the receiver is busy, a clean normal-mode pulse spans exactly three ticks, a falling `rx_nrz` is always preceded by enough consecutive high samples, and no receive low period runs beyond 16 ticks. Other behaviour can only be shown by the bench's scenarios. These are the pulse counts of whole frames for several byte values, and the scaling of width with the tick rate in normal mode as against the fixed width in low-power mode. They also cover the exact glitch boundary of 2 against 3 cycles, two received pulses one bit apart, and a frame whose first pulse is swallowed by an earlier reception.

// File: rtl/sir_pkg.sv
`timescale 1ns/1ps
package sir_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_PULSE = 2'd1,
        TX_GAP   = 2'd2
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_QUAL = 2'd1,
        RX_HOLD = 2'd2
    } rx_state_t;

endpackage

// File: rtl/sir_sync.sv
`timescale 1ns/1ps
module sir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sir_mod.sv
`timescale 1ns/1ps
module sir_mod
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int PULSE_TICKS   = 3,
    parameter int LP_TICKS      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic tick_fix,
    input  logic low_pwr,
    input  logic tx_bit,
    output logic pulse
);
    localparam int BIT_W  = $clog2(TICKS_PER_BIT);
    localparam int SLOT_W = $clog2(PULSE_TICKS + 1);
    localparam int FIX_W  = $clog2(LP_TICKS + 1);
    localparam logic [BIT_W-1:0]  LAST_TICK = BIT_W'(TICKS_PER_BIT - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PULSE_TICKS - 1);
    localparam logic [FIX_W-1:0]  LAST_FIX  = FIX_W'(LP_TICKS - 1);

    tx_state_t         state, state_nxt;
    logic [BIT_W-1:0]  bit_cnt, bit_cnt_nxt;
    logic [SLOT_W-1:0] slot_cnt, slot_cnt_nxt;
    logic [FIX_W-1:0]  fix_cnt, fix_cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            bit_cnt  <= '0;
            slot_cnt <= '0;
            fix_cnt  <= '0;
        end else begin
            state    <= state_nxt;
            bit_cnt  <= bit_cnt_nxt;
            slot_cnt <= slot_cnt_nxt;
            fix_cnt  <= fix_cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt    = state;
        bit_cnt_nxt  = bit_cnt;
        slot_cnt_nxt = slot_cnt;
        fix_cnt_nxt  = fix_cnt;
        unique case (state)
            TX_IDLE: begin
                if (tick16 && !tx_bit) begin
                    state_nxt    = TX_PULSE;
                    bit_cnt_nxt  = '0;
                    slot_cnt_nxt = '0;
                    fix_cnt_nxt  = '0;
                end
            end
            TX_PULSE, TX_GAP: begin
                if (tick16 && bit_cnt == LAST_TICK) begin
                    // bit end: the next bit decides
                    bit_cnt_nxt  = '0;
                    slot_cnt_nxt = '0;
                    fix_cnt_nxt  = '0;
                    state_nxt    = tx_bit ? TX_IDLE : TX_PULSE;
                end else begin
                    if (tick16) bit_cnt_nxt = bit_cnt + 1'b1;
                    if (state == TX_PULSE) begin
                        if (!low_pwr) begin
                            if (tick16) begin
                                if (slot_cnt == LAST_SLOT) state_nxt = TX_GAP;
                                else slot_cnt_nxt = slot_cnt + 1'b1;
                            end
                        end else if (tick_fix) begin
                            if (fix_cnt == LAST_FIX) state_nxt = TX_GAP;
                            else fix_cnt_nxt = fix_cnt + 1'b1;
                        end
                    end
                end
            end
            default: state_nxt = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pulse = (state == TX_PULSE);
    end
endmodule

// File: rtl/sir_demod.sv
`timescale 1ns/1ps
module sir_demod
    import sir_pkg::*;
#(
    parameter int TICKS_PER_BIT  = 16,
    parameter int MIN_PULSE_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic line,
    output logic busy,
    output logic hold
);
    localparam int BIT_W = $clog2(TICKS_PER_BIT);
    localparam int W_W   = $clog2(MIN_PULSE_CLKS + 1);
    localparam logic [BIT_W-1:0] LAST_TICK = BIT_W'(TICKS_PER_BIT - 1);
    localparam logic [W_W-1:0]   LAST_W    = W_W'(MIN_PULSE_CLKS - 1);
    localparam bit               ONE_CLK   = (MIN_PULSE_CLKS <= 1);

    rx_state_t        state, state_nxt;
    logic [W_W-1:0]   wcnt, wcnt_nxt;
    logic [BIT_W-1:0] hcnt, hcnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            wcnt  <= '0;
            hcnt  <= '0;
        end else begin
            state <= state_nxt;
            wcnt  <= wcnt_nxt;
            hcnt  <= hcnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        wcnt_nxt  = wcnt;
        hcnt_nxt  = hcnt;
        unique case (state)
            RX_IDLE: begin
                if (line) begin
                    if (ONE_CLK) begin
                        state_nxt = RX_HOLD;
                        hcnt_nxt  = '0;
                    end else begin
                        state_nxt = RX_QUAL;
                        wcnt_nxt  = W_W'(1);
                    end
                end
            end
            RX_QUAL: begin
                if (!line) begin
                    state_nxt = RX_IDLE;
                end else if (wcnt == LAST_W) begin
                    state_nxt = RX_HOLD;
                    hcnt_nxt  = '0;
                end else begin
                    wcnt_nxt = wcnt + 1'b1;
                end
            end
            RX_HOLD: begin
                if (tick16) begin
                    if (hcnt == LAST_TICK) state_nxt = RX_IDLE;
                    else hcnt_nxt = hcnt + 1'b1;
                end
            end
            default: state_nxt = RX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state != RX_IDLE);
        hold = (state == RX_HOLD);
    end
endmodule

// File: rtl/sir_codec.sv
`timescale 1ns/1ps
module sir_codec #(
    parameter int TICKS_PER_BIT  = 16,
    parameter int PULSE_TICKS    = 3,
    parameter int LP_TICKS       = 2,
    parameter int MIN_PULSE_CLKS = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic tick_fix,
    input  logic mod_en,
    input  logic low_pwr,
    input  logic tx_nrz,
    input  logic ir_rx,
    output logic ir_tx,
    output logic rx_nrz
);
    logic rx_sync;
    logic mod_pulse;
    logic dem_busy;
    logic dem_hold;

    sir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ir_rx),
        .q     (rx_sync)
    );

    sir_mod #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .PULSE_TICKS   (PULSE_TICKS),
        .LP_TICKS      (LP_TICKS)
    ) u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .tick_fix (tick_fix),
        .low_pwr  (low_pwr),
        .tx_bit   (tx_nrz),
        .pulse    (mod_pulse)
    );

    sir_demod #(
        .TICKS_PER_BIT  (TICKS_PER_BIT),
        .MIN_PULSE_CLKS (MIN_PULSE_CLKS)
    ) u_demod (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick16 (tick16),
        .line   (rx_sync),
        .busy   (dem_busy),
        .hold   (dem_hold)
    );

    // output select: pulse mode with echo blanking, or pass-through
    always_comb begin
        if (mod_en) begin
            ir_tx  = mod_pulse && !dem_busy;
            rx_nrz = !dem_hold;
        end else begin
            ir_tx  = tx_nrz;
            rx_nrz = rx_sync;
        end
    end
endmodule

// File: rtl/sir_codec_chk.sv
`timescale 1ns/1ps
module sir_codec_chk #(
    parameter int TICKS_PER_BIT  = 16,
    parameter int PULSE_TICKS    = 3,
    parameter int MIN_PULSE_CLKS = 3
) (
    input logic clk,
    input logic rst_n,
    input logic mod_en,
    input logic low_pwr,
    input logic tick16,
    input logic tx_nrz,
    input logic ir_tx,
    input logic rx_nrz,
    input logic rx_line,
    input logic rx_busy
);
    logic [7:0] hi_ticks;
    logic       clean;
    logic [7:0] hi_run;
    logic [7:0] lo_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_ticks <= '0;
            clean    <= 1'b0;
            hi_run   <= '0;
            lo_ticks <= '0;
        end else begin
            if (!ir_tx) begin
                hi_ticks <= '0;
                clean    <= mod_en && !low_pwr && !rx_busy;
            end else begin
                if (tick16) hi_ticks <= hi_ticks + 8'd1;
                if (low_pwr || !mod_en || rx_busy) clean <= 1'b0;
            end
            if (!rx_line)          hi_run <= '0;
            else if (hi_run != 8'hFF) hi_run <= hi_run + 8'd1;
            if (mod_en && !rx_nrz) begin
                if (tick16) lo_ticks <= lo_ticks + 8'd1;
            end else begin
                lo_ticks <= '0;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n && mod_en)
            assert_reset_idle_R8: assert (!ir_tx && rx_nrz)
                else $error("reset state wrong");
    end

    assert_echo_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && rx_busy) |-> !ir_tx);

    assert_pulse_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && $past(mod_en) && $rose(ir_tx) && !$past(rx_busy))
            |-> ($past(tick16) && !$past(tx_nrz)));

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ir_tx) && clean && mod_en && !low_pwr && !rx_busy)
            |-> (hi_ticks == 8'(PULSE_TICKS)));

    assert_glitch_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && $past(mod_en) && $fell(rx_nrz))
            |-> (hi_run >= 8'(MIN_PULSE_CLKS)));

    assert_hold_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && !rx_nrz) |-> (lo_ticks < 8'(TICKS_PER_BIT)));
endmodule

bind sir_codec sir_codec_chk #(
    .TICKS_PER_BIT  (TICKS_PER_BIT),
    .PULSE_TICKS    (PULSE_TICKS),
    .MIN_PULSE_CLKS (MIN_PULSE_CLKS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mod_en  (mod_en),
    .low_pwr (low_pwr),
    .tick16  (tick16),
    .tx_nrz  (tx_nrz),
    .ir_tx   (ir_tx),
    .rx_nrz  (rx_nrz),
    .rx_line (rx_sync),
    .rx_busy (dem_busy)
);

// File: tb/test_sir_codec.sv
`timescale 1ns/1ps
module test_sir_codec;
    logic clk = 1'b0;
    logic rst_n, tick16, tick_fix, mod_en, low_pwr, tx_nrz, ir_rx;
    logic ir_tx, rx_nrz;

    always #2.5 clk = ~clk;

    sir_codec i_sir_codec (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tick_fix(tick_fix),
        .mod_en(mod_en), .low_pwr(low_pwr), .tx_nrz(tx_nrz), .ir_rx(ir_rx),
        .ir_tx(ir_tx), .rx_nrz(rx_nrz)
    );

    int checks = 0;
    int fails  = 0;
    int div    = 4;
    int tcnt   = 0;
    int fcnt   = 0;
    int tx_np, tx_run, rx_np, rx_run;
    int tx_w [0:31];
    int rx_w [0:31];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: sample outputs, then drive tick strobes
    task automatic step();
        @(negedge clk);
        if (ir_tx === 1'b1) tx_run++;
        else if (tx_run > 0) begin
            if (tx_np < 32) tx_w[tx_np] = tx_run;
            tx_np++; tx_run = 0;
        end
        if (rx_nrz === 1'b0) rx_run++;
        else if (rx_run > 0) begin
            if (rx_np < 32) rx_w[rx_np] = rx_run;
            rx_np++; rx_run = 0;
        end
        tcnt++;
        if (tcnt >= div) begin tcnt = 0; tick16 = 1'b1; end else tick16 = 1'b0;
        fcnt++;
        if (fcnt >= 5) begin fcnt = 0; tick_fix = 1'b1; end else tick_fix = 1'b0;
    endtask

    task automatic clear_mon();
        tx_np = 0; tx_run = 0; rx_np = 0; rx_run = 0;
    endtask

    task automatic align();
        do step(); while (!tick16);
    endtask

    task automatic send_frame(input logic [7:0] b);
        logic [9:0] bits;
        bits = {1'b1, b, 1'b0};
        align();
        for (int i = 0; i < 10; i++) begin
            tx_nrz = bits[i];
            repeat (16 * div) step();
        end
        tx_nrz = 1'b1;
        repeat (8 * div) step();
    endtask

    task automatic rx_pulse(input int len);
        ir_rx = 1'b1;
        repeat (len) step();
        ir_rx = 1'b0;
    endtask

    task automatic settle();
        ir_rx = 1'b0; tx_nrz = 1'b1;
        repeat (20 * div) step();
        clear_mon();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mod_en = 1'b1;
        repeat (4) step();
        chk(ir_tx === 1'b0, "R8 ir_tx in reset", int'(ir_tx), 0);
        chk(rx_nrz === 1'b1, "R8 rx_nrz in reset", int'(rx_nrz), 1);
        rst_n = 1'b1;
        repeat (4) step();
        chk(ir_tx === 1'b0, "R2 idle ir_tx low after reset", int'(ir_tx), 0);
        clear_mon();
    endtask

    task automatic t_passthrough();
        mod_en = 1'b0;
        tx_nrz = 1'b0; step();
        chk(ir_tx === 1'b0, "R1 pass-through tx 0", int'(ir_tx), 0);
        tx_nrz = 1'b1; step();
        chk(ir_tx === 1'b1, "R1 pass-through tx 1", int'(ir_tx), 1);
        ir_rx = 1'b1; repeat (3) step();
        chk(rx_nrz === 1'b1, "R1 pass-through rx 1", int'(rx_nrz), 1);
        ir_rx = 1'b0; repeat (3) step();
        chk(rx_nrz === 1'b0, "R1 pass-through rx 0", int'(rx_nrz), 0);
        mod_en = 1'b1;
        settle();
    endtask

    task automatic t_frame(input logic [7:0] b, input int lp, input int d, input string tag);
        int zeros, wlo, whi;
        div = d; low_pwr = lp[0]; mod_en = 1'b1;
        settle();
        zeros = 1;
        for (int i = 0; i < 8; i++) if (!b[i]) zeros++;
        send_frame(b);
        chk(tx_np == zeros, {tag, " R9 pulse count"}, tx_np, zeros);
        if (lp != 0) begin wlo = 6; whi = 10; end
        else begin wlo = 3 * d; whi = 3 * d; end
        for (int i = 0; i < tx_np && i < 32; i++)
            chk(tx_w[i] >= wlo && tx_w[i] <= whi,
                {tag, (lp != 0) ? " R4 width" : " R3 width"}, tx_w[i], whi);
        low_pwr = 1'b0;
    endtask

    task automatic t_demod();
        div = 4; mod_en = 1'b1; settle();
        rx_pulse(4);
        repeat (20 * div) step();
        chk(rx_np == 1, "R5 one low period", rx_np, 1);
        chk(rx_w[0] >= 15 * div + 1 && rx_w[0] <= 16 * div, "R5 low length", rx_w[0], 16 * div);
    endtask

    task automatic t_glitch();
        div = 4; mod_en = 1'b1; settle();
        rx_pulse(1); repeat (20) step();
        rx_pulse(2); repeat (20 * div) step();
        chk(rx_np == 0, "R6 short glitches ignored", rx_np, 0);
        chk(rx_nrz === 1'b1, "R6 rx_nrz high after glitches", int'(rx_nrz), 1);
        rx_pulse(3); repeat (20 * div) step();
        chk(rx_np == 1, "R6 three-cycle pulse accepted", rx_np, 1);
    endtask

    task automatic t_two_pulses();
        div = 4; mod_en = 1'b1; settle();
        rx_pulse(12);
        repeat (16 * div - 12) step();
        rx_pulse(12);
        repeat (20 * div) step();
        chk(rx_np == 2, "R5 two consecutive zero bits", rx_np, 2);
    endtask

    task automatic t_blank();
        div = 4; mod_en = 1'b1; low_pwr = 1'b0; settle();
        rx_pulse(4);
        repeat (8) step();
        send_frame(8'h00);
        chk(tx_np == 8, "R7 first pulse blanked", tx_np, 8);
        chk(tx_w[0] == 12, "R7 later pulse intact", tx_w[0], 12);
        chk(rx_np == 1, "R7 echo-free reception", rx_np, 1);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick16 = 1'b0; tick_fix = 1'b0; mod_en = 1'b1; low_pwr = 1'b0;
        tx_nrz = 1'b1; ir_rx = 1'b0; rst_n = 1'b0;
        clear_mon();
        t_reset();
        t_passthrough();
        t_frame(8'h55, 0, 4, "0x55");
        t_frame(8'h00, 0, 4, "0x00 back-to-back");
        t_frame(8'hFF, 0, 4, "0xFF ones silent R2");
        t_frame(8'h0F, 0, 8, "0x0F slow baud");
        t_frame(8'h00, 1, 4, "low-power fast");
        t_frame(8'h00, 1, 8, "low-power slow");
        t_demod();
        t_glitch();
        t_two_pulses();
        t_blank();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule